// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level page table held in memory: a page directory, then a page table. It also supports 4 MB large pages, which are mapped directly by a directory entry. The walker takes one request at a time. Each request carries the address, whether the access is a write, and whether it comes from user mode. It also carries a snapshot of the control state: the root pointer of the directory, the paging enable, the supervisor write-protect switch, the large-page enable and the A20 address mask.

The walker reads 32-bit entries over a simple request/response memory port. It ANDs the user and read/write rights of the two levels. When an entry's accessed or dirty bit needs setting, it writes the entry back. It ends each walk with a one-cycle completion pulse. The pulse carries either a physical address with a writable flag, or a page-fault error code. A translation cache in front of the walker would use the writable flag to decide whether a later store can hit without another walk.

Top module: `pg_walker`

## Requirements
- R1: When paging is off at request time, the walk completes without any memory access, with no fault, with physical address = linear address AND A20 mask, and with the writable flag set.
- R2: The first memory access of a paged walk is a read at ((root AND 0xFFFFF000) + (linear[31:22] × 4)) AND A20 mask.
- R3: If an entry read at either level has bit 0 (present) clear, the walk ends in a fault with error bit 0 clear. No write-back of that entry or of any leaf entry follows.
- R4: A directory entry with bit 7 set maps a 4 MB page, but only while large pages are enabled. In that case no table read is made, and the physical address is {entry[31:22], linear[21:0]} AND A20 mask. With large pages disabled, bit 7 is ignored and the 4 KB path is taken.
- R5: On the 4 KB path the table entry is read at ((directory entry AND 0xFFFFF000) + (linear[21:12] × 4)) AND A20 mask. The physical address is {table entry[31:12], linear[11:0]} AND A20 mask.
- R6: The user right (bit 2) and the write right (bit 1) are the AND of the two levels; a large page uses the directory entry alone. The walk faults in three cases: a user access without the user right; a user write without the write right; a supervisor write without the write right while write-protect is on.
- R7: The fault error code has bit 0 = 1 for a rights fault (entry present), bit 1 = write access and bit 2 = user access. All other bits are zero. On success the code is zero.
- R8: After a successful check, the leaf entry (the table entry, or the directory entry of a large page) is written back to its own address when one of two things holds: bit 5 (accessed) is clear, or the access is a write and bit 6 (dirty) is clear. The written value has bit 5 set, and also bit 6 set for a write. If neither holds, nothing is written.
- R9: On the 4 KB path, a directory entry with bit 5 clear is written back with bit 5 set. This happens before the table read, so it happens even if the table entry later faults.
- R10: The writable flag is set only if the leaf is dirty after the walk and the write is allowed for the access's privilege. A user access needs the write right. A supervisor access needs the write right or write-protect off.
- R11: The request is accepted only while the walker is idle. A memory request stays asserted with a stable address and direction until it is accepted. Completion is a single-cycle pulse after which the walker is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqAddr | input | 32 | Linear address to translate |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access is from user mode |
| cfgRoot | input | 32 | Page directory base pointer |
| cfgPagingOn | input | 1 | Paging enabled |
| cfgWrProtect | input | 1 | Supervisor writes honour the write right |
| cfgLargeEn | input | 1 | 4 MB pages enabled |
| cfgA20Mask | input | 32 | Mask ANDed onto every physical address |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | Memory request is a write |
| memReqAddr | output | 32 | Memory request address |
| memReqWdata | output | 32 | Write data for entry write-back |
| memRspValid | input | 1 | Read data valid |
| memRspRdata | input | 32 | Read data |
| doneValid | output | 1 | Walk complete, one-cycle pulse |
| doneFault | output | 1 | Walk ended in a page fault |
| donePaddr | output | 32 | Physical address (zero on fault) |
| doneWritable | output | 1 | Translation may be used for writes |
| doneErr | output | 32 | Page-fault error code |

## Verification
Four properties are checked on every cycle:
- the memory handshake: requests are held stable until accepted, and there is no memory traffic while idle;
- the single-cycle completion pulse;
- every write-back carries the present and accepted bits set;
- the reserved error bits stay zero, and the error code is zero on success.

Other behaviour depends on table contents and sequences across walks, so only the bench's scenarios can show it:
- the address arithmetic at each level and the A20 masking;
- the order of the directory write-back against the table read;
- the rights combination across the two levels;
- when the writable flag is withheld for a clean page.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned PAGE_OFS_W = 12;
  localparam int unsigned BIG_OFS_W  = 22;
  localparam int unsigned IDX_W      = 10;
  localparam int unsigned ENT_B      = 2;   // log2 of entry size in bytes
  localparam int unsigned PTE_P  = 0;
  localparam int unsigned PTE_RW = 1;
  localparam int unsigned PTE_US = 2;
  localparam int unsigned PTE_A  = 5;
  localparam int unsigned PTE_D  = 6;
  localparam int unsigned PTE_PS = 7;
  localparam int unsigned ERR_W  = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FLAT, ST_DIR_RD, ST_DIR_WAIT, ST_DIR_EVAL, ST_DIR_WB,
    ST_TBL_RD, ST_TBL_WAIT, ST_TBL_EVAL, ST_LEAF_WB, ST_DONE
  } walkState_t;

  typedef enum logic [1:0] {RES_FLAT, RES_OK, RES_NP, RES_PROT} resKind_t;
  typedef enum logic [1:0] {MS_DIR_RD, MS_DIR_WB, MS_TBL_RD, MS_LEAF_WB} memSel_t;

  typedef struct packed {
    logic     latchReq;
    logic     capDir;
    logic     capTbl;
    logic     finish;
    resKind_t kind;
    memSel_t  memSel;
  } walkStrobe_t;

  typedef struct packed {
    logic dirPresent;
    logic dirLarge;
    logic dirAccessed;
    logic tblPresent;
    logic permFault;
    logic leafNeedWb;
  } walkStatus_t;
endpackage

// File: rtl/pgw_ctrl.sv
`timescale 1ns/1ps
module pgw_ctrl
  import pgw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        cfgPagingOn,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  walkStatus_t status,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        doneValid,
  output walkStrobe_t strobe
);
  walkState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState     = state;
    strobe        = '0;
    strobe.kind   = RES_OK;
    strobe.memSel = MS_DIR_RD;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          nextState = cfgPagingOn ? ST_DIR_RD : ST_FLAT;
        end
      end
      ST_FLAT: begin
        strobe.finish = 1'b1;
        strobe.kind   = RES_FLAT;
        nextState     = ST_DONE;
      end
      ST_DIR_RD: begin
        strobe.memSel = MS_DIR_RD;
        if (memReqReady) nextState = ST_DIR_WAIT;
      end
      ST_DIR_WAIT: begin
        if (memRspValid) begin
          strobe.capDir = 1'b1;
          nextState = ST_DIR_EVAL;
        end
      end
      ST_DIR_EVAL: begin
        if (!status.dirPresent) begin
          strobe.finish = 1'b1;
          strobe.kind   = RES_NP;
          nextState     = ST_DONE;
        end else if (status.dirLarge) begin
          if (status.permFault) begin
            strobe.finish = 1'b1;
            strobe.kind   = RES_PROT;
            nextState     = ST_DONE;
          end else if (status.leafNeedWb) begin
            nextState = ST_LEAF_WB;
          end else begin
            strobe.finish = 1'b1;
            nextState     = ST_DONE;
          end
        end else if (!status.dirAccessed) begin
          nextState = ST_DIR_WB;
        end else begin
          nextState = ST_TBL_RD;
        end
      end
      ST_DIR_WB: begin
        strobe.memSel = MS_DIR_WB;
        if (memReqReady) nextState = ST_TBL_RD;
      end
      ST_TBL_RD: begin
        strobe.memSel = MS_TBL_RD;
        if (memReqReady) nextState = ST_TBL_WAIT;
      end
      ST_TBL_WAIT: begin
        strobe.memSel = MS_TBL_RD;
        if (memRspValid) begin
          strobe.capTbl = 1'b1;
          nextState = ST_TBL_EVAL;
        end
      end
      ST_TBL_EVAL: begin
        strobe.memSel = MS_TBL_RD;
        if (!status.tblPresent) begin
          strobe.finish = 1'b1;
          strobe.kind   = RES_NP;
          nextState     = ST_DONE;
        end else if (status.permFault) begin
          strobe.finish = 1'b1;
          strobe.kind   = RES_PROT;
          nextState     = ST_DONE;
        end else if (status.leafNeedWb) begin
          nextState = ST_LEAF_WB;
        end else begin
          strobe.finish = 1'b1;
          nextState     = ST_DONE;
        end
      end
      ST_LEAF_WB: begin
        strobe.memSel = MS_LEAF_WB;
        if (memReqReady) begin
          strobe.finish = 1'b1;
          nextState     = ST_DONE;
        end
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign doneValid   = (state == ST_DONE);
  assign memReqValid = (state == ST_DIR_RD) || (state == ST_DIR_WB) ||
                       (state == ST_TBL_RD) || (state == ST_LEAF_WB);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid && reqReady); // R11
  AST_EVAL_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DIR_EVAL || state == ST_TBL_EVAL) |-> $past(memRspValid)); // R2
endmodule

// File: rtl/pgw_dpath.sv
`timescale 1ns/1ps
module pgw_dpath
  import pgw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [WORD_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic [WORD_W-1:0] cfgRoot,
  input  logic              cfgWrProtect,
  input  logic              cfgLargeEn,
  input  logic [WORD_W-1:0] cfgA20Mask,
  input  logic [WORD_W-1:0] memRspRdata,
  output walkStatus_t       status,
  output logic              memReqWrite,
  output logic [WORD_W-1:0] memReqAddr,
  output logic [WORD_W-1:0] memReqWdata,
  output logic              doneFault,
  output logic [WORD_W-1:0] donePaddr,
  output logic              doneWritable,
  output logic [WORD_W-1:0] doneErr
);
  localparam logic [WORD_W-1:0] FRAME_MASK = {{(WORD_W-PAGE_OFS_W){1'b1}}, {PAGE_OFS_W{1'b0}}};
  localparam logic [WORD_W-1:0] ACC_BIT    = WORD_W'(1) << PTE_A;
  localparam logic [WORD_W-1:0] DIRTY_BIT  = WORD_W'(1) << PTE_D;

  logic [WORD_W-1:0] rAddr, rRoot, rA20, rPde, rPte;
  logic              rWrite, rUser, rWp, rLarge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rAddr <= '0; rRoot <= '0; rA20 <= '0;
      rWrite <= 1'b0; rUser <= 1'b0; rWp <= 1'b0; rLarge <= 1'b0;
    end else if (strobe.latchReq) begin
      rAddr  <= reqAddr;
      rRoot  <= cfgRoot;
      rA20   <= cfgA20Mask;
      rWrite <= reqWrite;
      rUser  <= reqUser;
      rWp    <= cfgWrProtect;
      rLarge <= cfgLargeEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rPde <= '0;
      rPte <= '0;
    end else begin
      if (strobe.capDir) rPde <= memRspRdata;
      if (strobe.capTbl) rPte <= memRspRdata;
    end
  end

  // Entry addresses at both levels
  logic [WORD_W-1:0] dirAddr, tblAddr, leafAddr;
  assign dirAddr = ((rRoot & FRAME_MASK) +
                    {{(WORD_W-IDX_W-ENT_B){1'b0}}, rAddr[WORD_W-1 -: IDX_W], {ENT_B{1'b0}}}) & rA20;
  assign tblAddr = ((rPde & FRAME_MASK) +
                    {{(WORD_W-IDX_W-ENT_B){1'b0}}, rAddr[BIG_OFS_W-1 -: IDX_W], {ENT_B{1'b0}}}) & rA20;

  // Leaf selection and combined rights
  logic              isLarge, effUser, effRw;
  logic [WORD_W-1:0] leaf, leafWb, okPaddr;
  assign isLarge  = rPde[PTE_PS] & rLarge;
  assign leaf     = isLarge ? rPde : rPte;
  assign leafAddr = isLarge ? dirAddr : tblAddr;
  assign effUser  = isLarge ? rPde[PTE_US] : (rPde[PTE_US] & rPte[PTE_US]);
  assign effRw    = isLarge ? rPde[PTE_RW] : (rPde[PTE_RW] & rPte[PTE_RW]);
  assign leafWb   = leaf | ACC_BIT | (rWrite ? DIRTY_BIT : '0);
  assign okPaddr  = (isLarge ? {rPde[WORD_W-1:BIG_OFS_W], rAddr[BIG_OFS_W-1:0]}
                             : {rPte[WORD_W-1:PAGE_OFS_W], rAddr[PAGE_OFS_W-1:0]}) & rA20;

  always_comb begin
    status.dirPresent  = rPde[PTE_P];
    status.dirLarge    = isLarge;
    status.dirAccessed = rPde[PTE_A];
    status.tblPresent  = rPte[PTE_P];
    status.permFault   = (rUser & ~effUser) |
                         (rWrite & (rUser ? ~effRw : (rWp & ~effRw)));
    status.leafNeedWb  = ~leaf[PTE_A] | (rWrite & ~leaf[PTE_D]);
  end

  always_comb begin
    memReqWrite = 1'b0;
    memReqAddr  = dirAddr;
    memReqWdata = '0;
    unique case (strobe.memSel)
      MS_DIR_RD: memReqAddr = dirAddr;
      MS_DIR_WB: begin
        memReqWrite = 1'b1;
        memReqAddr  = dirAddr;
        memReqWdata = rPde | ACC_BIT;
      end
      MS_TBL_RD: memReqAddr = tblAddr;
      MS_LEAF_WB: begin
        memReqWrite = 1'b1;
        memReqAddr  = leafAddr;
        memReqWdata = leafWb;
      end
      default: memReqAddr = dirAddr;
    endcase
  end

  // Result register, loaded once per walk
  logic okWritable;
  assign okWritable = (leaf[PTE_D] | rWrite) & (rUser ? effRw : (~rWp | effRw));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFault <= 1'b0; donePaddr <= '0; doneWritable <= 1'b0; doneErr <= '0;
    end else if (strobe.finish) begin
      unique case (strobe.kind)
        RES_FLAT: begin
          doneFault <= 1'b0; donePaddr <= rAddr & rA20;
          doneWritable <= 1'b1; doneErr <= '0;
        end
        RES_OK: begin
          doneFault <= 1'b0; donePaddr <= okPaddr;
          doneWritable <= okWritable; doneErr <= '0;
        end
        default: begin
          doneFault    <= 1'b1;
          donePaddr    <= '0;
          doneWritable <= 1'b0;
          doneErr      <= {{(WORD_W-ERR_W){1'b0}}, rUser, rWrite, (strobe.kind == RES_PROT)};
        end
      endcase
    end
  end

  AST_WB_MARKS_ACCESSED: assert property (@(posedge clk) disable iff (!rstN)
    memReqWrite |-> memReqWdata[PTE_A] && memReqWdata[PTE_P]); // R8
endmodule

// File: rtl/pg_walker.sv
`timescale 1ns/1ps
module pg_walker
  import pgw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqAddr,
  input  logic        reqWrite,
  input  logic        reqUser,
  input  logic [31:0] cfgRoot,
  input  logic        cfgPagingOn,
  input  logic        cfgWrProtect,
  input  logic        cfgLargeEn,
  input  logic [31:0] cfgA20Mask,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic        memReqWrite,
  output logic [31:0] memReqAddr,
  output logic [31:0] memReqWdata,
  input  logic        memRspValid,
  input  logic [31:0] memRspRdata,
  output logic        doneValid,
  output logic        doneFault,
  output logic [31:0] donePaddr,
  output logic        doneWritable,
  output logic [31:0] doneErr
);
  walkStrobe_t strobe;
  walkStatus_t status;

  pgw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgPagingOn(cfgPagingOn),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .status(status),
    .reqReady(reqReady), .memReqValid(memReqValid), .doneValid(doneValid),
    .strobe(strobe)
  );

  pgw_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqUser(reqUser),
    .cfgRoot(cfgRoot), .cfgWrProtect(cfgWrProtect), .cfgLargeEn(cfgLargeEn),
    .cfgA20Mask(cfgA20Mask), .memRspRdata(memRspRdata), .status(status),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .doneFault(doneFault), .donePaddr(donePaddr), .doneWritable(doneWritable),
    .doneErr(doneErr)
  );

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqWrite)); // R11
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid); // R11
  AST_ERR_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> doneErr[31:3] == '0); // R7
  AST_OK_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && !doneFault |-> doneErr == '0); // R7
endmodule

// File: tb/test_pg_walker.sv
`timescale 1ns/1ps
module test_pg_walker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        reqValid = 1'b0, reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0, reqUser = 1'b0;
  logic [31:0] cfgRoot = '0;
  logic        cfgPagingOn = 1'b0, cfgWrProtect = 1'b0, cfgLargeEn = 1'b0;
  logic [31:0] cfgA20Mask = '1;
  logic        memReqValid, memReqWrite;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr, memReqWdata;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspRdata = '0;
  logic        doneValid, doneFault, doneWritable;
  logic [31:0] donePaddr, doneErr;

  pg_walker i_pg_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqUser(reqUser),
    .cfgRoot(cfgRoot), .cfgPagingOn(cfgPagingOn), .cfgWrProtect(cfgWrProtect),
    .cfgLargeEn(cfgLargeEn), .cfgA20Mask(cfgA20Mask),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memRspValid(memRspValid), .memRspRdata(memRspRdata),
    .doneValid(doneValid), .doneFault(doneFault), .donePaddr(donePaddr),
    .doneWritable(doneWritable), .doneErr(doneErr)
  );

  typedef struct {
    bit          wr;
    logic [31:0] addr;
    logic [31:0] data;
  } acc_t;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] dutMem[logic [31:0]];
  logic [31:0] modMem[logic [31:0]];
  acc_t        expQ[$];
  bit          expFault, expWritable;
  logic [31:0] expPaddr, expErr;
  string       curTag = "R11";
  bit          waiting = 1'b0, gotDone = 1'b0;
  bit          pendRd = 1'b0;
  logic [31:0] pendAddr = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modRd(input logic [31:0] a);
    return modMem.exists(a) ? modMem[a] : 32'h0;
  endfunction

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    dutMem[a] = d;
    modMem[a] = d;
  endtask

  // Behavioural expectation of one walk: fills expQ and the expected result
  task automatic model(input logic [31:0] la, input bit wr, input bit us, input bit pg,
                       input bit wp, input bit pse, input logic [31:0] root,
                       input logic [31:0] a20);
    logic [31:0] dA, tA, lA, pde, pte, leaf, pa;
    bit u, rw;
    expQ.delete();
    expFault = 0; expErr = 0; expWritable = 0; expPaddr = 0;
    if (!pg) begin
      expPaddr = la & a20; expWritable = 1;
      return;
    end
    dA = ((root & 32'hFFFF_F000) + ((la >> 20) & 32'hFFC)) & a20;
    expQ.push_back('{0, dA, 0});
    pde = modRd(dA);
    if (!pde[0]) begin
      expFault = 1; expErr = {29'd0, us, wr, 1'b0};
      return;
    end
    if (pde[7] && pse) begin
      u = pde[2]; rw = pde[1]; leaf = pde; lA = dA;
      pa = ((pde & 32'hFFC0_0000) | (la & 32'h003F_FFFF)) & a20;
    end else begin
      if (!pde[5]) begin
        modMem[dA] = pde | 32'h20;
        expQ.push_back('{1, dA, pde | 32'h20});
      end
      tA = ((pde & 32'hFFFF_F000) + ((la >> 10) & 32'hFFC)) & a20;
      expQ.push_back('{0, tA, 0});
      pte = modRd(tA);
      if (!pte[0]) begin
        expFault = 1; expErr = {29'd0, us, wr, 1'b0};
        return;
      end
      u = pde[2] & pte[2]; rw = pde[1] & pte[1]; leaf = pte; lA = tA;
      pa = ((pte & 32'hFFFF_F000) | (la & 32'hFFF)) & a20;
    end
    if ((us && !u) || (wr && (us ? !rw : (wp && !rw)))) begin
      expFault = 1; expErr = {29'd0, us, wr, 1'b1};
      return;
    end
    if (!leaf[5] || (wr && !leaf[6])) begin
      modMem[lA] = leaf | 32'h20 | (wr ? 32'h40 : 32'h0);
      expQ.push_back('{1, lA, modMem[lA]});
    end
    expPaddr = pa;
    expWritable = (leaf[6] || wr) && (us ? rw : (!wp || rw));
  endtask

  // Memory model and per-cycle comparison
  always @(negedge clk) begin
    if (rstN) begin : mon
      acc_t e;
      memRspValid = 1'b0;
      if (pendRd) begin
        memRspValid = 1'b1;
        memRspRdata = dutMem.exists(pendAddr) ? dutMem[pendAddr] : 32'h0;
        pendRd = 1'b0;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      memReqReady = lfsr[0] | lfsr[3];
      if (memReqValid && memReqReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, curTag, "unexpected memory access", memReqAddr, 32'h0);
        end else begin
          e = expQ.pop_front();
          check(memReqWrite == e.wr, curTag, "access direction", {31'd0, memReqWrite}, {31'd0, e.wr});
          check(memReqAddr == e.addr, curTag, "access address", memReqAddr, e.addr);
          if (e.wr) check(memReqWdata == e.data, curTag, "write-back data", memReqWdata, e.data);
        end
        if (memReqWrite) dutMem[memReqAddr] = memReqWdata;
        else begin pendRd = 1'b1; pendAddr = memReqAddr; end
      end
      if (doneValid) begin
        if (!waiting) check(1'b0, curTag, "spurious done", 32'h1, 32'h0);
        check(doneFault == expFault, curTag, "fault flag", {31'd0, doneFault}, {31'd0, expFault});
        check(doneErr == expErr, curTag, "error code", doneErr, expErr);
        if (!expFault) begin
          check(donePaddr == expPaddr, curTag, "physical address", donePaddr, expPaddr);
          check(doneWritable == expWritable, curTag, "writable flag",
                {31'd0, doneWritable}, {31'd0, expWritable});
        end
        check(expQ.size() == 0, curTag, "missing accesses", expQ.size(), 32'h0);
        waiting = 1'b0;
        gotDone = 1'b1;
      end
    end
  end

  task automatic walk(input string tag, input logic [31:0] la, input bit wr, input bit us,
                      input bit pg, input bit wp, input bit pse,
                      input logic [31:0] root, input logic [31:0] a20);
    @(negedge clk);
    curTag = tag;
    model(la, wr, us, pg, wp, pse, root, a20);
    reqAddr = la; reqWrite = wr; reqUser = us; cfgPagingOn = pg;
    cfgWrProtect = wp; cfgLargeEn = pse; cfgRoot = root; cfgA20Mask = a20;
    gotDone = 1'b0; waiting = 1'b1;
    check(reqReady == 1'b1, "R11", "ready before request", {31'd0, reqReady}, 32'h1);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    wait (gotDone);
    @(negedge clk);
  endtask

  localparam logic [31:0] ROOT = 32'h0020_0000;
  localparam logic [31:0] ALL  = 32'hFFFF_FFFF;
  localparam logic [31:0] NOA20 = 32'hFFEF_FFFF;

  initial begin : watchdog
    #(5 * 150000);
    nFails++;
    $display("FAIL R11 watchdog: got hung walk expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    // Directory entries
    poke(ROOT + 32'h4,  32'h0030_0007);      // idx1 -> table 0x300000, A clear
    poke(ROOT + 32'hC,  32'h0031_0007);      // idx3 -> table with empty slot
    poke(ROOT + 32'h10, 32'h0F80_0087);      // idx4 large page, A clear
    // Table entries
    poke(32'h0030_000C, 32'h0ABC_D007);      // rw+user, clean
    poke(32'h0030_0014, 32'h0111_1003);      // rw, no user
    poke(32'h0030_0018, 32'h0222_2005);      // user, read-only
    poke(32'h0F80_08D0, 32'h0555_5067);      // used when large pages off
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R11", "reset ready", {31'd0, reqReady}, 32'h1);
    check(memReqValid == 1'b0, "R11", "reset mem idle", {31'd0, memReqValid}, 32'h0);
    check(doneValid == 1'b0, "R11", "reset done low", {31'd0, doneValid}, 32'h0);

    walk("R1", 32'h1234_5678, 1, 1, 0, 1, 1, ROOT, ALL);
    walk("R1", 32'h0012_3456, 0, 0, 0, 0, 0, ROOT, NOA20);
    walk("R3", 32'h0080_0000, 1, 1, 1, 0, 1, ROOT, ALL);      // dir idx2 empty
    walk("R9", 32'h0040_3123, 0, 0, 1, 0, 1, ROOT, ALL);      // dir+leaf A write-back, R5 R10
    walk("R8", 32'h0040_3123, 1, 0, 1, 0, 1, ROOT, ALL);      // dirty set on write
    walk("R8", 32'h0040_3123, 1, 1, 1, 1, 1, ROOT, ALL);      // nothing to write back
    walk("R6", 32'h0040_5456, 0, 1, 1, 0, 1, ROOT, ALL);      // user without user right
    walk("R7", 32'h0040_6789, 1, 1, 1, 0, 1, ROOT, ALL);      // user write read-only
    walk("R6", 32'h0040_6789, 1, 0, 1, 1, 1, ROOT, ALL);      // supervisor write, protect on
    walk("R6", 32'h0040_6789, 1, 0, 1, 0, 1, ROOT, ALL);      // supervisor write, protect off
    walk("R10", 32'h0040_6789, 0, 0, 1, 1, 1, ROOT, ALL);     // dirty but not writable
    walk("R10", 32'h0040_5456, 0, 0, 1, 0, 1, ROOT, ALL);     // clean read, not writable
    walk("R9", 32'h00C0_1000, 0, 0, 1, 0, 1, ROOT, ALL);      // dir A set, then table absent
    walk("R4", 32'h0123_4567, 1, 1, 1, 0, 1, ROOT, ALL);      // large page, leaf dirty
    walk("R4", 32'h0123_4567, 0, 0, 1, 0, 0, ROOT, ALL);      // large bit ignored
    walk("R2", 32'h0040_3123, 0, 0, 1, 0, 1, 32'h0030_0000, NOA20); // A20 on every address, R5
    walk("R5", 32'h0040_3FFF, 0, 1, 1, 0, 1, ROOT, ALL);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule